// File: doc/BRIEF.md
# Bank-Multiplexed Processor Bus Glue

This block sits between a 16-bit-address processor and its memories and peripherals. The processor uses its eight data lines for two things in each clock phase cycle. While PHI2 is low it puts the upper eight address bits (the bank) on them. While PHI2 is high it uses them for data. The block keeps the bank in a latch that is open during the low phase and closed during the high phase. It joins the bank to the 16-bit address to form a 24-bit address. From that address it makes three active-low device selects.

The block also makes the active-low read and write strobes and drives the enable and direction of a bidirectional data buffer. It keeps every strobe, select and buffer enable inactive during the low phase, so nothing fights the bank bits on the shared lines. Every select is also blocked while neither valid-address input (data-address valid or program-address valid) is asserted.

The block runs on a fast system clock. All processor inputs pass through the same two-flop synchronizer, so they stay aligned to each other. Strobes open one extra system clock after the synchronized PHI2 rise, which leaves turnaround time on the bus.

Top module: `cpu_bus_glue`

## Requirements
- R1: While synchronized PHI2 is low, `bank` follows `dbus` without inversion, two clocks late. While PHI2 is high, `bank` holds the value the data lines carried in the last low-phase sample, even if `dbus` changes at the rising edge.
- R2: `full_addr` equals `{bank, addr}`. Bits 23:16 are the bank and bits 15:0 are the synchronized address.
- R3: `oe_n` and `we_n` are both high whenever PHI2, sampled two clocks earlier, is low.
- R4: Three clocks after PHI2 rises, `oe_n` is low if `rwb` is 1 and `we_n` is low if `rwb` is 0. The two strobes are never low together.
- R5: The selects are decoded from the 24-bit address. `io_sel_n` is low when the bank is $00 and `addr[15:8]` is $C0. Otherwise `ram_sel_n` is low for banks $00 to $7F and `rom_sel_n` is low for banks $80 to $FF. At most one select is low at a time.
- R6: No select is low while `vda` and `vpa` are both 0. Either one at 1 enables decoding.
- R7: `buf_en_n` is low only during the strobe phase of R4 while a select is low. `buf_dir` is 1 (toward the processor) when `rwb` is 1 and 0 (toward the devices) when `rwb` is 0.
- R8: No select and no buffer enable is asserted while PHI2, sampled two clocks earlier, is low.
- R9: While `rst_n` is low, `oe_n`, `we_n`, all three selects and `buf_en_n` are 1, and `bank` is 0, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than PHI2 |
| rst_n | input | 1 | Active-low synchronous reset |
| phi2 | input | 1 | Processor phase clock |
| rwb | input | 1 | 1 = read, 0 = write |
| vda | input | 1 | Data address valid |
| vpa | input | 1 | Program address valid |
| addr | input | 16 | Low 16 address bits from processor |
| dbus | input | 8 | Processor data lines (bank during low phase) |
| bank | output | 8 | Latched bank address |
| full_addr | output | 24 | Combined 24-bit address |
| oe_n | output | 1 | Read strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| ram_sel_n | output | 1 | RAM select, active low |
| io_sel_n | output | 1 | I/O page select, active low |
| rom_sel_n | output | 1 | ROM select, active low |
| buf_en_n | output | 1 | Data buffer enable, active low |
| buf_dir | output | 1 | Buffer direction, 1 = toward processor |

## Verification
At the PHI2 rise, two things happen in the same synchronized cycle: the bank latch closes and the strobe and select logic starts decoding. The bench provokes this by switching the data lines from the bank value to its complement on the same clock where PHI2 rises, as a processor does when it turns the lines to data. In the high phase it then checks that `bank`, `full_addr` and the chosen select still reflect the low-phase bank rather than the new data. The sweep repeats this over bank values on both sides of each region boundary, over pages next to the I/O page, over both directions and over all four valid-address combinations.

// File: rtl/cpu_bus_glue.sv
module cpu_bus_glue #(
  parameter logic [7:0] RAM_LAST_BANK = 8'h7F,
  parameter logic [7:0] IO_BANK       = 8'h00,
  parameter logic [7:0] IO_PAGE       = 8'hC0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        phi2,
  input  logic        rwb,
  input  logic        vda,
  input  logic        vpa,
  input  logic [15:0] addr,
  input  logic [7:0]  dbus,
  output logic [7:0]  bank,
  output logic [23:0] full_addr,
  output logic        oe_n,
  output logic        we_n,
  output logic        ram_sel_n,
  output logic        io_sel_n,
  output logic        rom_sel_n,
  output logic        buf_en_n,
  output logic        buf_dir
);

  localparam int SW = 4 + 16 + 8;

  logic [SW-1:0] meta, sync;
  logic          phi2_s, rwb_s, vda_s, vpa_s;
  logic [15:0]   addr_s;
  logic [7:0]    d_s;
  logic          phi2_d;
  logic [7:0]    bank_q;
  logic          phase_hi, valid, is_io, is_ram, is_rom;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta   <= '0;
      sync   <= '0;
      phi2_d <= 1'b0;
      bank_q <= '0;
    end else begin
      meta   <= {phi2, rwb, vda, vpa, addr, dbus};
      sync   <= meta;
      phi2_d <= phi2_s;
      if (!phi2_s) bank_q <= d_s;
    end
  end

  assign {phi2_s, rwb_s, vda_s, vpa_s, addr_s, d_s} = sync;

  assign bank      = phi2_s ? bank_q : d_s;
  assign full_addr = {bank, addr_s};

  assign phase_hi = phi2_s & phi2_d;
  assign valid    = vda_s | vpa_s;

  assign is_io  = (bank == IO_BANK) && (addr_s[15:8] == IO_PAGE);
  assign is_ram = !is_io && (bank <= RAM_LAST_BANK);
  assign is_rom = !is_io && (bank >  RAM_LAST_BANK);

  assign oe_n      = !(phase_hi &&  rwb_s);
  assign we_n      = !(phase_hi && !rwb_s);
  assign io_sel_n  = !(phase_hi && valid && is_io);
  assign ram_sel_n = !(phase_hi && valid && is_ram);
  assign rom_sel_n = !(phase_hi && valid && is_rom);
  assign buf_en_n  = io_sel_n && ram_sel_n && rom_sel_n;
  assign buf_dir   = rwb_s;

  a_r1_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (phi2_s && $past(phi2_s)) |-> $stable(bank));

  a_r3_strobes_quiet_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(phi2, 2) |-> (oe_n && we_n));

  a_r4_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n || we_n);

  a_r5_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~ram_sel_n, ~io_sel_n, ~rom_sel_n}) <= 1);

  a_r6_invalid_no_select: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(vda, 2) && !$past(vpa, 2)) |-> (ram_sel_n && io_sel_n && rom_sel_n));

  a_r8_buffer_quiet_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(phi2, 2) |-> (buf_en_n && ram_sel_n && io_sel_n && rom_sel_n));

endmodule

// File: tb/test_cpu_bus_glue.sv
module test_cpu_bus_glue;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phi2 = 1'b1, rwb = 1'b1, vda = 1'b1, vpa = 1'b1;
  logic [15:0] addr = 16'hC000;
  logic [7:0]  dbus = 8'hA5;
  logic [7:0]  bank;
  logic [23:0] full_addr;
  logic        oe_n, we_n, ram_sel_n, io_sel_n, rom_sel_n, buf_en_n, buf_dir;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cpu_bus_glue i_cpu_bus_glue (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .rwb(rwb), .vda(vda), .vpa(vpa),
    .addr(addr), .dbus(dbus), .bank(bank), .full_addr(full_addr),
    .oe_n(oe_n), .we_n(we_n), .ram_sel_n(ram_sel_n), .io_sel_n(io_sel_n),
    .rom_sel_n(rom_sel_n), .buf_en_n(buf_en_n), .buf_dir(buf_dir)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_clocks(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_cycle(input logic [7:0] b, input logic [15:0] a,
                           input logic rw, input logic da, input logic pa);
    logic v, io, ram, rom;
    phi2 = 1'b0; dbus = b; addr = a; rwb = rw; vda = da; vpa = pa;
    wait_clocks(3);
    check("R1 bank open", bank, b);
    check("R2 full address low phase", full_addr, {b, a});
    check("R3 strobes quiet low", {oe_n, we_n}, 2'b11);
    check("R8 selects and buffer quiet low",
          {ram_sel_n, io_sel_n, rom_sel_n, buf_en_n}, 4'hF);
    phi2 = 1'b1; dbus = ~b;
    wait_clocks(3);
    v   = da | pa;
    io  = (b == 8'h00) && (a[15:8] == 8'hC0);
    ram = !io && (b <= 8'h7F);
    rom = !io && (b >= 8'h80);
    check("R1 bank held high", bank, b);
    check("R2 full address high phase", full_addr, {b, a});
    check("R4 strobes", {oe_n, we_n}, {!rw, rw});
    check("R5 R6 selects", {ram_sel_n, io_sel_n, rom_sel_n},
          {!(v && ram), !(v && io), !(v && rom)});
    check("R7 buffer", {buf_en_n, buf_dir}, {!v, rw});
  endtask

  initial begin
    logic [7:0]  banks [0:9];
    logic [7:0]  pages [0:4];
    banks = '{8'h00, 8'h01, 8'h3C, 8'h7E, 8'h7F, 8'h80, 8'h81, 8'hC0, 8'hFE, 8'hFF};
    pages = '{8'hC0, 8'hBF, 8'hC1, 8'h00, 8'hFF};
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R9 reset strobes selects buffer",
          {oe_n, we_n, ram_sel_n, io_sel_n, rom_sel_n, buf_en_n}, 6'h3F);
    check("R9 reset bank", bank, 8'h00);
    rst_n = 1'b1;
    for (int bi = 0; bi < 10; bi++)
      for (int pi = 0; pi < 5; pi++)
        for (int k = 0; k < 8; k++)
          bus_cycle(banks[bi], {pages[pi], 8'h5A ^ 8'(k * 37)}, k[0], k[1], k[2]);
    phi2 = 1'b0; dbus = 8'h12;
    wait_clocks(3);
    for (int i = 0; i < 4; i++) begin
      dbus = 8'h12 + 8'(i * 51);
      wait_clocks(2);
      check("R1 bank follows data two clocks late", bank, 8'h12 + 8'(i * 51));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule